// File: doc/BRIEF.md
# Debug Event Queue with Instruction Cycle Stamps

This block buffers watch and breakpoint hits raised by a bus monitor so that a slow host can collect them later. Each hit carries the instruction address, the bus address and data of the access, and a 4-bit kind code. The block stamps each entry with the cycle count taken when the guilty instruction began, not when the hit arrived. A free-running cycle counter advances only while the monitored CPU runs. An instruction-start strobe copies that counter into a start-of-instruction register, and this register is what goes into the queue.

The oldest entry is always on view through a byte-wide readback selector, so the host can read every field without a pop. A pop command retires the oldest entry. A flush command clears the whole queue. A pending output tells the host that at least one entry waits. When the queue is full, new hits are lost and nothing reports the loss.

Top module: `dbg_evt_fifo`

## Requirements
- R1: After a synchronous reset, `evt_pending` is low, `rd_data` is zero and the cycle counter and start-of-instruction register are zero.
- R2: A hit presented with `evt_valid` high in a clock cycle, with the queue not full and no flush, is stored. Entries leave in arrival order.
- R3: `rd_data` is registered and shows, one cycle after `rd_sel` is applied, a byte of the oldest entry: select 6/7 instruction address low/high byte, 8/9 bus address low/high byte, 10 data byte, 11 kind code in bits 3..0 with bits 7..4 zero. No pop is needed.
- R4: Any select outside 6..14 (including 15), and every select while the queue is empty, reads zero.
- R5: A pop retires the oldest entry and exposes the next one. A pop on an empty queue has no effect. A pop and a hit in the same cycle with one entry held leaves the new hit as the oldest entry.
- R6: A flush empties the queue within one cycle. It overrides a pop and drops a hit in the same cycle.
- R7: With DEPTH entries held, a further hit is dropped even if a pop occurs in the same cycle, and the held entries stay intact.
- R8: The cycle counter advances by one in each cycle with `cpu_run` high, holds otherwise, and wraps modulo 2^CNT_W.
- R9: `insn_start` copies the counter value from before that edge into the start-of-instruction register. A stored hit carries this register's value from before its capture edge. The stamp is read at select 12/13/14 as low/middle/high byte, zero-extended to 24 bits.
- R10: `evt_pending` is registered and is high exactly when the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_run | input | 1 | Monitored CPU is running; counter enable |
| insn_start | input | 1 | First cycle of a new instruction |
| evt_valid | input | 1 | A watch/breakpoint hit is presented |
| evt_iaddr | input | 16 | Address of the instruction that caused the hit |
| evt_baddr | input | 16 | Bus address of the access |
| evt_data | input | 8 | Bus data of the access |
| evt_mode | input | 4 | Kind code of the hit |
| evt_pop | input | 1 | Retire the oldest entry |
| evt_flush | input | 1 | Empty the queue |
| rd_sel | input | 6 | Readback byte selector |
| rd_data | output | 8 | Selected readback byte (registered) |
| evt_pending | output | 1 | Queue holds at least one entry |

## Verification
The bench builds the block with DEPTH set to 16 and CNT_W set to 10. At that depth the random push/pop mix fills the queue within tens of cycles, so overflow drops, draining from full and the pointer wrap all occur many times. A 10-bit counter wraps every 1024 running cycles, so stamps that cross the wrap are reached. The same setting makes the upper stamp bits read back as zero through the zero-extension path.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
  localparam int RB_W = 8;

  typedef enum logic [5:0] {
    RB_IA_LO  = 6'd6,
    RB_IA_HI  = 6'd7,
    RB_BA_LO  = 6'd8,
    RB_BA_HI  = 6'd9,
    RB_DATA   = 6'd10,
    RB_MODE   = 6'd11,
    RB_CY_LO  = 6'd12,
    RB_CY_MID = 6'd13,
    RB_CY_HI  = 6'd14
  } rb_sel_e;
endpackage

// File: rtl/dbgf_cyc.sv
module dbgf_cyc #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             insn_start,
  output logic [CNT_W-1:0] stamp
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      stamp_q <= '0;
    end else begin
      if (run)        cnt_q   <= cnt_q + CNT_W'(1);
      if (insn_start) stamp_q <= cnt_q;
    end
  end

  assign stamp = stamp_q;

  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
  p_stamp_latch_r9: assert property (@(posedge clk) disable iff (rst)
    insn_start |=> stamp_q == $past(cnt_q));
endmodule

// File: rtl/dbgf_store.sv
module dbgf_store #(
  parameter int ENT_W = 72,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ENT_W-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [ENT_W-1:0] head,
  output logic             nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, rd_q, rd_nxt, wr_nxt;
  logic [CW-1:0]    cnt_q, cnt_nxt, remain;
  logic             wr_ok, rd_ok, byp;
  logic [ENT_W-1:0] head_q;
  logic             ne_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ok   = push && (cnt_q != CW'(DEPTH)) && !flush;
    rd_ok   = pop && (cnt_q != '0) && !flush;
    rd_nxt  = rd_ok ? bump(rd_q) : rd_q;
    wr_nxt  = wr_ok ? bump(wr_q) : wr_q;
    remain  = cnt_q - CW'(rd_ok);
    byp     = (remain == '0);
    cnt_nxt = remain + CW'(wr_ok);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    head_q <= byp ? wdata : mem[rd_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ne_q  <= 1'b0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
      ne_q  <= (cnt_nxt != '0);
    end
  end

  assign head     = head_q;
  assign nonempty = ne_q;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(DEPTH) && !pop && !flush) |=> cnt_q == CW'(DEPTH));
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt_q == '0 && !push) |=> cnt_q == '0);
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0 && !nonempty));
  p_pending_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> nonempty);
endmodule

// File: rtl/dbgf_rdmux.sv
module dbgf_rdmux
  import dbgf_pkg::*;
#(
  parameter int IA_W  = 16,
  parameter int BA_W  = 16,
  parameter int D_W   = 8,
  parameter int M_W   = 4,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [IA_W-1:0]  ia,
  input  logic [BA_W-1:0]  ba,
  input  logic [D_W-1:0]   dat,
  input  logic [M_W-1:0]   mode,
  input  logic [CNT_W-1:0] cyc,
  input  logic [5:0]       sel,
  output logic [RB_W-1:0]  rd_data
);
  logic [15:0]     ia16, ba16;
  logic [7:0]      d8, m8;
  logic [23:0]     cy24;
  logic [RB_W-1:0] pick, rd_q;

  always_comb begin
    ia16 = 16'(ia);
    ba16 = 16'(ba);
    d8   = 8'(dat);
    m8   = 8'(mode);
    cy24 = 24'(cyc);
    case (sel)
      RB_IA_LO:  pick = ia16[7:0];
      RB_IA_HI:  pick = ia16[15:8];
      RB_BA_LO:  pick = ba16[7:0];
      RB_BA_HI:  pick = ba16[15:8];
      RB_DATA:   pick = d8;
      RB_MODE:   pick = m8;
      RB_CY_LO:  pick = cy24[7:0];
      RB_CY_MID: pick = cy24[15:8];
      RB_CY_HI:  pick = cy24[23:16];
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (valid) rd_q <= pick;
    else            rd_q <= '0;
  end

  assign rd_data = rd_q;

  p_spare_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == 6'd15) |=> rd_data == '0);
  p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !valid |=> rd_data == '0);
endmodule

// File: rtl/dbg_evt_fifo.sv
module dbg_evt_fifo #(
  parameter int DEPTH = 512,
  parameter int IA_W  = 16,
  parameter int BA_W  = 16,
  parameter int D_W   = 8,
  parameter int M_W   = 4,
  parameter int CNT_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_run,
  input  logic            insn_start,
  input  logic            evt_valid,
  input  logic [IA_W-1:0] evt_iaddr,
  input  logic [BA_W-1:0] evt_baddr,
  input  logic [D_W-1:0]  evt_data,
  input  logic [M_W-1:0]  evt_mode,
  input  logic            evt_pop,
  input  logic            evt_flush,
  input  logic [5:0]      rd_sel,
  output logic [7:0]      rd_data,
  output logic            evt_pending
);
  localparam int O_IA  = 0;
  localparam int O_BA  = O_IA + IA_W;
  localparam int O_D   = O_BA + BA_W;
  localparam int O_M   = O_D + D_W;
  localparam int O_CY  = O_M + M_W;
  localparam int ENT_W = O_CY + CNT_W;

  logic [CNT_W-1:0] stamp;
  logic [ENT_W-1:0] wentry, hentry;
  logic             nonempty;

  dbgf_cyc #(.CNT_W(CNT_W)) cyc_i (
    .clk(clk), .rst(rst), .run(cpu_run), .insn_start(insn_start), .stamp(stamp)
  );

  assign wentry = {stamp, evt_mode, evt_data, evt_baddr, evt_iaddr};

  dbgf_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push(evt_valid), .wdata(wentry),
    .pop(evt_pop), .flush(evt_flush), .head(hentry), .nonempty(nonempty)
  );

  dbgf_rdmux #(.IA_W(IA_W), .BA_W(BA_W), .D_W(D_W), .M_W(M_W), .CNT_W(CNT_W)) mux_i (
    .clk(clk), .rst(rst), .valid(nonempty),
    .ia(hentry[O_IA +: IA_W]), .ba(hentry[O_BA +: BA_W]),
    .dat(hentry[O_D +: D_W]), .mode(hentry[O_M +: M_W]),
    .cyc(hentry[O_CY +: CNT_W]), .sel(rd_sel), .rd_data(rd_data)
  );

  assign evt_pending = nonempty;
endmodule

// File: tb/dbg_evt_fifo_tb_top.sv
module dbg_evt_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = 10;
  localparam int ENT_W = 16 + 16 + 8 + 4 + CNT_W;

  logic clk = 1'b0;
  logic rst, cpu_run, insn_start, evt_valid, evt_pop, evt_flush;
  logic [15:0] evt_iaddr, evt_baddr;
  logic [7:0]  evt_data, rd_data;
  logic [3:0]  evt_mode;
  logic [5:0]  rd_sel;
  logic        evt_pending;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [ENT_W-1:0] q[$];
  int unsigned m_cnt, m_stamp;

  always #5 clk = ~clk;

  dbg_evt_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cpu_run(cpu_run), .insn_start(insn_start),
    .evt_valid(evt_valid), .evt_iaddr(evt_iaddr), .evt_baddr(evt_baddr),
    .evt_data(evt_data), .evt_mode(evt_mode), .evt_pop(evt_pop),
    .evt_flush(evt_flush), .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_pending(evt_pending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected readback byte from the model's oldest entry (R3, R4, R9)
  function automatic logic [7:0] rb(input logic [5:0] s);
    logic [ENT_W-1:0] e;
    logic [23:0] cy;
    if (q.size() == 0) return 8'h00;
    e  = q[0];
    cy = 24'(e[ENT_W-1 -: CNT_W]);
    case (s)
      6'd6:  return e[7:0];
      6'd7:  return e[15:8];
      6'd8:  return e[23:16];
      6'd9:  return e[31:24];
      6'd10: return e[39:32];
      6'd11: return {4'h0, e[43:40]};
      6'd12: return cy[7:0];
      6'd13: return cy[15:8];
      6'd14: return cy[23:16];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] s, input int sz);
    if (sz == 0) return "R4 empty";
    if (s >= 6 && s <= 11) return "R2 R3 head field";
    if (s >= 12 && s <= 14) return "R8 R9 stamp";
    return "R4 spare select";
  endfunction

  // One clock: drive at negedge, update model for the edge, check after it
  task automatic tick(input bit run, input bit ist, input bit ev,
                      input logic [15:0] ia, input logic [15:0] ba,
                      input logic [7:0] d, input logic [3:0] m,
                      input bit p, input bit f, input logic [5:0] s);
    logic [7:0] exp_rd;
    string tg;
    bit push_ok, pop_ok;
    cpu_run = run; insn_start = ist; evt_valid = ev; evt_iaddr = ia;
    evt_baddr = ba; evt_data = d; evt_mode = m; evt_pop = p;
    evt_flush = f; rd_sel = s;
    exp_rd = rb(s);
    tg = tag_of(s, q.size());
    push_ok = ev && (q.size() < DEPTH) && !f;
    pop_ok  = p && (q.size() > 0) && !f;
    if (f) q.delete();
    else begin
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back({CNT_W'(m_stamp), m, d, ba, ia});
    end
    if (ist) m_stamp = m_cnt;
    if (run) m_cnt = (m_cnt + 1) % (1 << CNT_W);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data === exp_rd, tg, rd_data, exp_rd);
    chk(evt_pending === (q.size() != 0), "R10 pending", evt_pending, q.size() != 0);
  endtask

  task automatic rnd(input int n, input int pe, input int pp, input int pf);
    for (int i = 0; i < n; i++) begin
      logic [5:0] s;
      s = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'(6 + $urandom % 10);
      tick(($urandom % 10) < 8, ($urandom % 10) < 2, ($urandom % 100) < pe,
           16'($urandom), 16'($urandom), 8'($urandom), 4'($urandom),
           ($urandom % 100) < pp, ($urandom % 1000) < pf, s);
    end
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; cpu_run = 1'b1; insn_start = 1'b1; evt_valid = 1'b1;
    evt_iaddr = '0; evt_baddr = '0; evt_data = '0; evt_mode = '0;
    evt_pop = 1'b0; evt_flush = 1'b0; rd_sel = 6'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(evt_pending === 1'b0, "R1 pending after reset", evt_pending, 0);
    chk(rd_data === 8'h00, "R1 rd_data after reset", rd_data, 0);
    rst = 1'b0;
    m_cnt = 0; m_stamp = 0;

    // R5: pop on empty is ignored
    tick(0, 0, 0, 0, 0, 0, 0, 1, 0, 6);
    chk(evt_pending === 1'b0, "R5 pop on empty", evt_pending, 0);
    // R1: stamp after reset is zero, R9 stamp capture
    tick(0, 0, 1, 16'hA1B2, 16'hC3D4, 8'h5E, 4'h9, 0, 0, 6);
    tick(1, 1, 0, 0, 0, 0, 0, 0, 0, 12);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 12);
    chk(rd_data === 8'h00, "R1 R9 stamp zero after reset", rd_data, 0);
    // Head fields visible without pop, spare selects read zero (R3, R4)
    for (int s = 0; s < 16; s++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 6'(s));
    // R5: pop plus push with one entry held
    tick(1, 1, 1, 16'h1111, 16'h2222, 8'h33, 4'h4, 1, 0, 7);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 7);
    chk(rd_data === 8'h11, "R5 new head after pop+push", rd_data, 8'h11);
    // R6: flush overrides pop and drops a hit
    tick(0, 0, 1, 16'hFFFF, 0, 0, 0, 1, 1, 6);
    chk(evt_pending === 1'b0, "R6 flush empties", evt_pending, 0);
    // R7: fill, overflow attempt with pop, drain
    for (int i = 0; i < DEPTH; i++)
      tick(1, 1, 1, 16'(i), 16'(~i), 8'(i * 3), 4'(i), 0, 0, 6);
    tick(1, 0, 1, 16'hDEAD, 16'hBEEF, 8'h77, 4'h7, 0, 0, 8);
    tick(1, 0, 1, 16'hDEAD, 16'hBEEF, 8'h77, 4'h7, 1, 0, 8);
    chk(q.size() == DEPTH - 1 && evt_pending, "R7 drop at full", q.size(), DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++)
      tick(0, 0, 0, 0, 0, 0, 0, 1, 0, 6'(6 + (i % 9)));
    chk(evt_pending === 1'b0, "R7 drained count", evt_pending, 0);
    // Random traffic: filling phase, draining phase, balanced phase (R8 wrap)
    rnd(1500, 60, 30, 5);
    rnd(1500, 25, 70, 5);
    rnd(3000, 40, 40, 3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule